// File: doc/BRIEF.md
# Instruction Prefix and Immediate Collector

This block sits in an instruction fetch front end and sees the instruction stream one byte per cycle. While an instruction's leading bytes arrive, it recognises legacy prefix bytes and folds them into a packed 8-bit prefix vector. Bytes that are not prefixes, such as opcode bytes, are left to other logic. The block combines the operand-size override bit of that vector with a REX.W indication and the processor mode to produce the effective operand size. Both the REX indication and the mode come from outside.

Once opcode decode knows the instruction's immediate class, it pulses `imm_start` with a 4-bit type code. The block then looks up the immediate length for that class at the resolved operand size. It takes that many following bytes, least significant first, and raises a one-cycle ready pulse with the assembled 64-bit value. A pulse on `insn_start` begins a new instruction: it clears the prefix vector and abandons any collection in progress.

The controller has three states. `ST_PREFIX` gathers prefixes and waits for the strobe. `ST_IMM` accepts immediate bytes. `ST_DONE` presents the result for one cycle. The transitions are:
- PREFIX→IMM on a strobe with a non-zero length.
- PREFIX→DONE on a strobe with a zero length.
- IMM→DONE on the final immediate byte.
- DONE→PREFIX always.
- Any state→PREFIX on `insn_start`, which has the highest priority.

Top module: `pfx_imm_collector`

## Requirements
- R1: In `ST_PREFIX`, each accepted prefix byte sets one flag in `pfx_vec`: 0x66 sets bit 3 (operand size), 0x67 sets bit 4 (address size), 0xF0 sets bit 5 (lock), 0xF3 sets bit 6 (rep) and 0xF2 sets bit 7 (repne). Flags accumulate until `insn_start`.
- R2: `pfx_vec[2:0]` holds one segment code: 0 none, 1 for 0x2E, 2 for 0x3E, 3 for 0x26, 4 for 0x64, 5 for 0x65, 6 for 0x36. A later segment byte replaces an earlier one, and code 7 never appears.
- R3: Non-prefix bytes in `ST_PREFIX` leave `pfx_vec` unchanged. Bytes accepted in `ST_IMM` are treated as immediate data and never alter `pfx_vec`.
- R4: `op_size` encodes 1 = 16-bit, 2 = 32-bit, 3 = 64-bit and is never 0. With `mode` 2 or 3 (64-bit), `rex_present` together with `rex_w` gives 3. Otherwise in that mode the override flag gives 1, and no override gives 2.
- R5: With `mode` 1 (32-bit default), the override flag gives 1 and no override gives 2. With `mode` 0 (16-bit default), the override flag gives 2 and no override gives 1.
- R6: Immediate byte counts for type codes 0..9 at sizes 16/32/64 are:
  - 0 none: 0
  - 1 byte: 1
  - 2 word: 2
  - 3 dword: 4
  - 4 qword: 8
  - 5 oword: 16
  - 6 vword: 2/4/4
  - 7 zword: 2/4/8
  - 8 enter: 3
  - 9 pointer: 4/6/0
  - codes 10..15: 0
- R7: Immediate byte i is placed at bits 8i+7:8i. Bytes beyond the eighth are consumed but dropped. `imm_ready` is high for exactly one cycle, the cycle after the final byte is accepted, with `imm_value` valid in that cycle.
- R8: When the length is exactly 4, `imm_value[63:32]` is a copy of bit 31. Other lengths are zero-extended.
- R9: A zero-length immediate raises `imm_ready` in the cycle after the `imm_start` strobe, with `imm_value` equal to 0.
- R10: `insn_start` clears `pfx_vec`, the byte counter and the value, and returns the controller to `ST_PREFIX` without a ready pulse. A following immediate is assembled from byte 0.
- R11: After reset, `pfx_vec` is 0, `imm_value` is 0 and `imm_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_start | input | 1 | Begin a new instruction; clears the collected state |
| byte_vld | input | 1 | `byte_in` carries a valid instruction byte this cycle |
| byte_in | input | 8 | Instruction byte |
| rex_present | input | 1 | A REX prefix was seen for this instruction |
| rex_w | input | 1 | The REX W bit |
| mode | input | 2 | 0 = 16-bit default, 1 = 32-bit default, 2/3 = 64-bit |
| imm_start | input | 1 | Strobe: opcode known, start immediate collection |
| imm_type | input | 4 | Immediate type code, sampled with `imm_start` |
| pfx_vec | output | 8 | Packed prefix vector |
| op_size | output | 2 | Effective operand size code |
| imm_value | output | 64 | Assembled immediate |
| imm_ready | output | 1 | One-cycle pulse: `imm_value` is complete |

## Verification
The assertions assume that `imm_start` is only pulsed while the controller waits in `ST_PREFIX`. They also assume that `rex_present`, `rex_w` and `mode` stay steady between the strobe and the ready pulse. The bench keeps to this: it changes the mode and REX inputs only between collections. It never asserts `byte_vld` together with a strobe. Every collection it starts is either run to completion or cut short by `insn_start`.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int IMM_W         = 64;
    localparam int MAX_IMM_BYTES = 16;
    localparam int LEN_W         = $clog2(MAX_IMM_BYTES + 1);
    localparam int LANES         = IMM_W / 8;
    localparam int TYPE_W        = 4;
    localparam int MODE_W        = 2;

    typedef enum logic [1:0] {
        ST_PREFIX = 2'd0,
        ST_IMM    = 2'd1,
        ST_DONE   = 2'd2
    } pic_state_e;

    typedef enum logic [1:0] {
        OSZ_NONE = 2'd0,
        OSZ_16   = 2'd1,
        OSZ_32   = 2'd2,
        OSZ_64   = 2'd3
    } osz_e;

    typedef struct packed {
        logic       repne;
        logic       rep;
        logic       lock;
        logic       asz;
        logic       osz;
        logic [2:0] seg;
    } pfx_vec_t;

    localparam logic [MODE_W-1:0] MODE_16 = 2'd0;
    localparam logic [MODE_W-1:0] MODE_32 = 2'd1;

    localparam logic [TYPE_W-1:0] IT_NONE  = 4'd0;
    localparam logic [TYPE_W-1:0] IT_BYTE  = 4'd1;
    localparam logic [TYPE_W-1:0] IT_WORD  = 4'd2;
    localparam logic [TYPE_W-1:0] IT_DWORD = 4'd3;
    localparam logic [TYPE_W-1:0] IT_QWORD = 4'd4;
    localparam logic [TYPE_W-1:0] IT_OWORD = 4'd5;
    localparam logic [TYPE_W-1:0] IT_VWORD = 4'd6;
    localparam logic [TYPE_W-1:0] IT_ZWORD = 4'd7;
    localparam logic [TYPE_W-1:0] IT_ENTER = 4'd8;
    localparam logic [TYPE_W-1:0] IT_PTR   = 4'd9;
endpackage

// File: rtl/pic_prefix_decode.sv
module pic_prefix_decode
    import pic_pkg::*;
(
    input  pfx_vec_t   cur,
    input  logic [7:0] byte_in,
    output pfx_vec_t   nxt,
    output logic       hit
);
    always_comb begin
        nxt = cur;
        hit = 1'b1;
        unique case (byte_in)
            8'h66:   nxt.osz   = 1'b1;
            8'h67:   nxt.asz   = 1'b1;
            8'hF0:   nxt.lock  = 1'b1;
            8'hF3:   nxt.rep   = 1'b1;
            8'hF2:   nxt.repne = 1'b1;
            8'h2E:   nxt.seg   = 3'd1;
            8'h3E:   nxt.seg   = 3'd2;
            8'h26:   nxt.seg   = 3'd3;
            8'h64:   nxt.seg   = 3'd4;
            8'h65:   nxt.seg   = 3'd5;
            8'h36:   nxt.seg   = 3'd6;
            default: hit       = 1'b0;
        endcase
    end
endmodule

// File: rtl/pic_opsize.sv
module pic_opsize
    import pic_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              rex_present,
    input  logic              rex_w,
    input  logic              ovr,
    output osz_e              osz
);
    always_comb begin
        unique case (mode)
            MODE_16: osz = ovr ? OSZ_32 : OSZ_16;
            MODE_32: osz = ovr ? OSZ_16 : OSZ_32;
            default: begin
                if (rex_present && rex_w) osz = OSZ_64;
                else if (ovr)             osz = OSZ_16;
                else                      osz = OSZ_32;
            end
        endcase
    end
endmodule

// File: rtl/pic_immlen.sv
module pic_immlen
    import pic_pkg::*;
(
    input  logic [TYPE_W-1:0] ityp,
    input  osz_e              osz,
    output logic [LEN_W-1:0]  len
);
    always_comb begin
        unique case (ityp)
            IT_BYTE:  len = LEN_W'(1);
            IT_WORD:  len = LEN_W'(2);
            IT_DWORD: len = LEN_W'(4);
            IT_QWORD: len = LEN_W'(8);
            IT_OWORD: len = LEN_W'(16);
            IT_ENTER: len = LEN_W'(3);
            IT_VWORD: len = (osz == OSZ_16) ? LEN_W'(2) : LEN_W'(4);
            IT_ZWORD: len = (osz == OSZ_16) ? LEN_W'(2) :
                            (osz == OSZ_64) ? LEN_W'(8) : LEN_W'(4);
            IT_PTR:   len = (osz == OSZ_16) ? LEN_W'(4) :
                            (osz == OSZ_64) ? LEN_W'(0) : LEN_W'(6);
            default:  len = LEN_W'(0);
        endcase
    end
endmodule

// File: rtl/pfx_imm_collector.sv
module pfx_imm_collector
    import pic_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        insn_start,
    input  logic        byte_vld,
    input  logic [7:0]  byte_in,
    input  logic        rex_present,
    input  logic        rex_w,
    input  logic [1:0]  mode,
    input  logic        imm_start,
    input  logic [3:0]  imm_type,
    output logic [7:0]  pfx_vec,
    output logic [1:0]  op_size,
    output logic [63:0] imm_value,
    output logic        imm_ready
);
    pic_state_e             state_q, state_d;
    pfx_vec_t               pfx_q, pfx_dec;
    logic                   dec_hit;
    osz_e                   osz_w;
    logic [LEN_W-1:0]       len_w, len_q, cnt_q;
    logic [IMM_W-1:0]       acc_q, acc_d, acc_ins;
    logic [LANES-1:0][7:0]  lane_d;
    logic                   take_imm, last_byte;

    pic_prefix_decode u_dec (
        .cur     (pfx_q),
        .byte_in (byte_in),
        .nxt     (pfx_dec),
        .hit     (dec_hit)
    );

    pic_opsize u_osz (
        .mode        (mode),
        .rex_present (rex_present),
        .rex_w       (rex_w),
        .ovr         (pfx_q.osz),
        .osz         (osz_w)
    );

    pic_immlen u_len (
        .ityp (imm_type),
        .osz  (osz_w),
        .len  (len_w)
    );

    assign take_imm  = (state_q == ST_IMM) && byte_vld;
    assign last_byte = take_imm && (cnt_q == len_q - LEN_W'(1));

    // per-lane write of the incoming immediate byte
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_comb begin
            if (take_imm && (cnt_q == LEN_W'(k)))
                lane_d[k] = byte_in;
            else
                lane_d[k] = acc_q[k*8 +: 8];
        end
    end

    always_comb begin
        acc_ins = lane_d;
        if (last_byte && (len_q == LEN_W'(4)))
            acc_d = {{(IMM_W-32){acc_ins[31]}}, acc_ins[31:0]};
        else
            acc_d = acc_ins;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (insn_start) begin
            state_d = ST_PREFIX;
        end else begin
            unique case (state_q)
                ST_PREFIX: if (imm_start)
                               state_d = (len_w == '0) ? ST_DONE : ST_IMM;
                ST_IMM:    if (last_byte) state_d = ST_DONE;
                ST_DONE:   state_d = ST_PREFIX;
                default:   state_d = ST_PREFIX;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PREFIX;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pfx_q <= '0;
            len_q <= '0;
            cnt_q <= '0;
            acc_q <= '0;
        end else if (insn_start) begin
            pfx_q <= '0;
            len_q <= '0;
            cnt_q <= '0;
            acc_q <= '0;
        end else begin
            unique case (state_q)
                ST_PREFIX: begin
                    if (imm_start) begin
                        len_q <= len_w;
                        cnt_q <= '0;
                        acc_q <= '0;
                    end else if (byte_vld && dec_hit) begin
                        pfx_q <= pfx_dec;
                    end
                end
                ST_IMM: begin
                    if (byte_vld) begin
                        cnt_q <= cnt_q + LEN_W'(1);
                        acc_q <= acc_d;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        pfx_vec   = pfx_q;
        op_size   = osz_w;
        imm_value = acc_q;
        imm_ready = (state_q == ST_DONE);
    end
endmodule

// File: rtl/pic_checker.sv
module pic_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        insn_start,
    input logic        imm_start,
    input logic [7:0]  pfx_vec,
    input logic [1:0]  op_size,
    input logic [63:0] imm_value,
    input logic        imm_ready,
    input logic [1:0]  st,
    input logic [4:0]  len_q,
    input logic [4:0]  len_w
);
    p_seg_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pfx_vec[2:0] != 3'd7);

    p_pfx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'd1 && !insn_start) |=> $stable(pfx_vec));

    p_osize_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_size != 2'd0);

    p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        imm_ready |=> !imm_ready);

    p_sext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_ready && len_q == 5'd4) |-> (imm_value[63:32] == {32{imm_value[31]}}));

    p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'd0 && imm_start && !insn_start && len_w == 5'd0) |=> imm_ready);

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        insn_start |=> (pfx_vec == 8'd0 && !imm_ready));
endmodule

bind pfx_imm_collector pic_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_start (insn_start),
    .imm_start  (imm_start),
    .pfx_vec    (pfx_vec),
    .op_size    (op_size),
    .imm_value  (imm_value),
    .imm_ready  (imm_ready),
    .st         (state_q),
    .len_q      (len_q),
    .len_w      (len_w)
);

// File: tb/pfx_imm_collector_bench.sv
module pfx_imm_collector_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_start = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic        rex_present = 1'b0;
    logic        rex_w = 1'b0;
    logic [1:0]  mode = 2'd2;
    logic        imm_start = 1'b0;
    logic [3:0]  imm_type = 4'd0;
    logic [7:0]  pfx_vec;
    logic [1:0]  op_size;
    logic [63:0] imm_value;
    logic        imm_ready;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pfx_imm_collector u_pfx_imm_collector (
        .clk(clk), .rst_n(rst_n), .insn_start(insn_start), .byte_vld(byte_vld),
        .byte_in(byte_in), .rex_present(rex_present), .rex_w(rex_w), .mode(mode),
        .imm_start(imm_start), .imm_type(imm_type), .pfx_vec(pfx_vec),
        .op_size(op_size), .imm_value(imm_value), .imm_ready(imm_ready)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int t, input int sz);
        case (t)
            1: return 1;
            2: return 2;
            3: return 4;
            4: return 8;
            5: return 16;
            6: return (sz == 1) ? 2 : 4;
            7: return (sz == 1) ? 2 : (sz == 2) ? 4 : 8;
            8: return 3;
            9: return (sz == 1) ? 4 : (sz == 2) ? 6 : 0;
            default: return 0;
        endcase
    endfunction

    // all tasks start and end just after a falling edge
    task automatic pulse_insn();
        insn_start = 1'b1;
        @(negedge clk);
        insn_start = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        byte_vld = 1'b1;
        byte_in  = b;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic run_imm(input logic [3:0] t, input int n, input logic [7:0] seed, input string req);
        logic [63:0] e = 64'd0;
        imm_type  = t;
        imm_start = 1'b1;
        @(negedge clk);
        imm_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            logic [7:0] b = seed + 8'(i * 19);
            chk(imm_ready == 1'b0, {req, " early ready"}, 64'(imm_ready), 64'd0);
            if (i < 8) e[i*8 +: 8] = b;
            byte_vld = 1'b1;
            byte_in  = b;
            @(negedge clk);
        end
        byte_vld = 1'b0;
        if (n == 4) e = {{32{e[31]}}, e[31:0]};
        chk(imm_ready == 1'b1, {req, " ready"}, 64'(imm_ready), 64'd1);
        chk(imm_value == e, {req, " value"}, imm_value, e);
        @(negedge clk);
        chk(imm_ready == 1'b0, "R7 ready one cycle", 64'(imm_ready), 64'd0);
    endtask

    task automatic t_reset();
        chk(pfx_vec == 8'h00, "R11 pfx after reset", 64'(pfx_vec), 64'd0);
        chk(imm_value == 64'd0, "R11 value after reset", imm_value, 64'd0);
        chk(imm_ready == 1'b0, "R11 ready after reset", 64'(imm_ready), 64'd0);
    endtask

    task automatic t_prefix_flags();
        pulse_insn();
        send_byte(8'h66); chk(pfx_vec == 8'h08, "R1 0x66", 64'(pfx_vec), 64'h08);
        send_byte(8'h67); chk(pfx_vec == 8'h18, "R1 0x67", 64'(pfx_vec), 64'h18);
        send_byte(8'hF0); chk(pfx_vec == 8'h38, "R1 0xF0", 64'(pfx_vec), 64'h38);
        send_byte(8'hF3); chk(pfx_vec == 8'h78, "R1 0xF3", 64'(pfx_vec), 64'h78);
        send_byte(8'hF2); chk(pfx_vec == 8'hF8, "R1 0xF2", 64'(pfx_vec), 64'hF8);
        pulse_insn();
        send_byte(8'hF2); chk(pfx_vec == 8'h80, "R1 repne alone", 64'(pfx_vec), 64'h80);
    endtask

    task automatic t_segments();
        logic [7:0] codes [6] = '{8'h2E, 8'h3E, 8'h26, 8'h64, 8'h65, 8'h36};
        pulse_insn();
        send_byte(8'hF0);
        for (int i = 0; i < 6; i++) begin
            send_byte(codes[i]);
            chk(pfx_vec == (8'h20 | 8'(i + 1)), "R2 segment code, last wins",
                64'(pfx_vec), 64'(8'h20 | 8'(i + 1)));
        end
        send_byte(8'h2E);
        chk(pfx_vec == 8'h21, "R2 replace SS by CS", 64'(pfx_vec), 64'h21);
    endtask

    task automatic t_ignored();
        pulse_insn();
        mode = 2'd1;
        send_byte(8'h66);
        send_byte(8'h90);
        send_byte(8'h0F);
        chk(pfx_vec == 8'h08, "R3 non-prefix ignored", 64'(pfx_vec), 64'h08);
        // word at 16-bit size: two bytes, both look like prefixes
        imm_type = 4'd2; imm_start = 1'b1; @(negedge clk); imm_start = 1'b0;
        send_byte(8'hF0);
        chk(pfx_vec == 8'h08, "R3 imm byte not a prefix", 64'(pfx_vec), 64'h08);
        send_byte(8'h2E);
        chk(pfx_vec == 8'h08, "R3 pfx held", 64'(pfx_vec), 64'h08);
        chk(imm_ready && imm_value == 64'h2EF0, "R3 imm bytes kept",
            imm_value, 64'h2EF0);
        @(negedge clk);
    endtask

    task automatic t_opsize();
        pulse_insn();
        mode = 2'd2; rex_present = 1'b1; rex_w = 1'b1; #1;
        chk(op_size == 2'd3, "R4 rex.w 64", 64'(op_size), 64'd3);
        rex_w = 1'b0; #1;
        chk(op_size == 2'd2, "R4 rex no w", 64'(op_size), 64'd2);
        rex_present = 1'b0; rex_w = 1'b1; #1;
        chk(op_size == 2'd2, "R4 w without rex", 64'(op_size), 64'd2);
        mode = 2'd3; rex_present = 1'b1; #1;
        chk(op_size == 2'd3, "R4 mode 3 as 64", 64'(op_size), 64'd3);
        mode = 2'd1; #1;
        chk(op_size == 2'd2, "R5 32 default", 64'(op_size), 64'd2);
        mode = 2'd0; #1;
        chk(op_size == 2'd1, "R5 16 default", 64'(op_size), 64'd1);
        @(negedge clk);
        send_byte(8'h66);
        chk(op_size == 2'd2, "R5 16 default with ovr", 64'(op_size), 64'd2);
        mode = 2'd1; #1;
        chk(op_size == 2'd1, "R5 32 default with ovr", 64'(op_size), 64'd1);
        mode = 2'd2; rex_present = 1'b0; #1;
        chk(op_size == 2'd1, "R4 64 ovr no rex", 64'(op_size), 64'd1);
        rex_present = 1'b1; rex_w = 1'b1; #1;
        chk(op_size == 2'd3, "R4 rex.w beats ovr", 64'(op_size), 64'd3);
        rex_present = 1'b0; rex_w = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_lengths();
        for (int sz = 1; sz <= 3; sz++) begin
            mode = (sz == 1) ? 2'd0 : (sz == 2) ? 2'd1 : 2'd2;
            rex_present = (sz == 3); rex_w = (sz == 3);
            for (int t = 0; t < 11; t++) begin
                pulse_insn();
                run_imm(4'(t), exp_len(t, sz), 8'(8'h81 + t * 7 + sz), "R6 R7 length");
            end
        end
        rex_present = 1'b0; rex_w = 1'b0;
    endtask

    task automatic t_sext();
        mode = 2'd1;
        pulse_insn();
        run_imm(4'd3, 4, 8'h21, "R8 dword");   // byte3 = 0x21+57 = 0x5A, positive
        pulse_insn();
        run_imm(4'd3, 4, 8'h4F, "R8 dword neg"); // byte3 = 0x88, negative
        pulse_insn();
        run_imm(4'd7, 4, 8'hC0, "R8 zword 32");
        mode = 2'd2; rex_present = 1'b1; rex_w = 1'b1;
        pulse_insn();
        run_imm(4'd4, 8, 8'h4F, "R8 qword no sext");
        rex_present = 1'b0; rex_w = 1'b0;
    endtask

    task automatic t_zero();
        mode = 2'd2; rex_present = 1'b1; rex_w = 1'b1;
        pulse_insn();
        run_imm(4'd9, 0, 8'h00, "R9 pointer in 64");
        pulse_insn();
        run_imm(4'd0, 0, 8'h00, "R9 none");
        rex_present = 1'b0; rex_w = 1'b0;
    endtask

    task automatic t_abort();
        mode = 2'd1;
        pulse_insn();
        send_byte(8'h66);
        imm_type = 4'd2; imm_start = 1'b1; @(negedge clk); imm_start = 1'b0;
        send_byte(8'h55);
        pulse_insn();
        chk(pfx_vec == 8'h00, "R10 pfx cleared", 64'(pfx_vec), 64'd0);
        chk(imm_ready == 1'b0, "R10 no ready", 64'(imm_ready), 64'd0);
        send_byte(8'h77);
        chk(imm_ready == 1'b0, "R10 still no ready", 64'(imm_ready), 64'd0);
        pulse_insn();
        run_imm(4'd3, 4, 8'h10, "R10 fresh count");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prefix_flags();
        t_segments();
        t_ignored();
        t_opsize();
        t_lengths();
        t_sext();
        t_zero();
        t_abort();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule